// File: doc/BRIEF.md
# Product-Term Array with Allocator

This block is a programmable sum-of-products logic slice. It takes 36 routed input signals and offers each one in true and complemented form, which gives 72 literal columns. A programmable AND plane forms 86 product terms from those columns. A steering stage then builds each of 16 sum outputs as the OR of a configured subset of the terms. Any output may draw on anywhere from none to sixteen terms. One term may feed several outputs, so a term that many outputs need is built only once.

The configuration image holds the AND-plane connections, a per-term use flag and the per-output selection masks. It is loaded bit by bit through a serial shift chain into a shadow copy, while the logic keeps running on the active copy. An apply strobe copies the shadow into the active copy, but only when every output selects at most sixteen terms. Otherwise the image is refused, an error flag rises, and the old image stays in force.

The path from the inputs to the sums contains no registers. Its delay does not depend on how many terms are used or how widely they are shared.

Top module: `sop_block`

## Requirements
- R1: Literal column 2i carries in_sig[i] and column 2i+1 carries ~in_sig[i]. A used product term is 1 exactly when every literal column connected to it is 1.
- R2: A used product term with no connected columns evaluates to 1.
- R3: A product term whose use flag is 0 evaluates to 0, whatever its connections are.
- R4: Each sum_out[o] is the OR of the product terms selected in its mask. A single term may be selected by several outputs at once, and an output may select up to 16 terms.
- R5: An output whose mask selects no term drives 0.
- R6: While cfg_load is 1, each rising clock edge shifts the shadow image: shadow becomes {shadow[W-2:0], cfg_sin}. cfg_sout always shows shadow[W-1]. While cfg_load is 0, the shadow does not change.
- R7: Image layout, with W = 7654. Term t occupies bits t*73 to t*73+71; bit t*73+c connects column c. Bit t*73+72 is the term's use flag. Bit 6278 + o*86 + t selects term t for output o.
- R8: The active image changes only at a rising edge where cfg_apply is 1. While a new image is being shifted in, sum_out keeps following the old active image.
- R9: An apply whose shadow mask sets more than 16 bits for any output is refused: the active image is kept and cfg_err is 1 from the next cycle on. An accepted apply copies the shadow into the active image and clears cfg_err.
- R10: During reset, the shadow image and the active image are all zero, so sum_out is 0, cfg_err is 0 and cfg_sout is 0.
- R11: sum_out follows a change on in_sig with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the configuration logic |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| in_sig | input | 36 | Routed data inputs to the AND plane |
| cfg_load | input | 1 | Shift enable for the shadow image |
| cfg_sin | input | 1 | Serial configuration data in |
| cfg_apply | input | 1 | Copies the shadow image into the active image if it passes the limit check |
| cfg_sout | output | 1 | Serial configuration data out (shadow MSB) |
| cfg_err | output | 1 | Set when the last apply was refused |
| sum_out | output | 16 | Sum-of-products outputs |

## Verification
The assertions take for granted that cfg_apply and cfg_load are clean synchronous levels. They also assume the active image only ever comes from an accepted apply, so every active mask stays within sixteen terms. The stimulus keeps to this by driving every control input at the falling edge and by raising cfg_apply only after a full image of W bits has been shifted in. Random images always draw between zero and sixteen distinct terms per output. The one image that goes over the limit is built on purpose so that its refusal can be checked.

// File: rtl/sop_pkg.sv
package sop_pkg;
  localparam int unsigned SOP_INPUTS     = 36;
  localparam int unsigned SOP_TERMS      = 86;
  localparam int unsigned SOP_SUMS       = 16;
  localparam int unsigned SOP_TERM_LIMIT = 16;

  // literal column numbering shared by plane and bench (R1)
  function automatic int unsigned col_true(input int unsigned i);
    return 2 * i;
  endfunction

  function automatic int unsigned col_comp(input int unsigned i);
    return 2 * i + 1;
  endfunction
endpackage

// File: rtl/sop_rst_sync.sv
module sop_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q     <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      meta_q     <= 1'b1;
      rst_sync_n <= meta_q;
    end
  end
endmodule

// File: rtl/sop_cfg_store.sv
module sop_cfg_store #(
  parameter int unsigned N_PT       = 86,
  parameter int unsigned N_OUT      = 16,
  parameter int unsigned TERM_LIMIT = 16,
  parameter int unsigned AND_BITS   = 6278
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      cfg_load,
  input  logic                      cfg_sin,
  input  logic                      cfg_apply,
  output logic                      cfg_sout,
  output logic                      cfg_err,
  output logic [AND_BITS-1:0]       and_cfg,
  output logic [N_OUT*N_PT-1:0]     mask_cfg
);
  localparam int unsigned MASK_BITS = N_OUT * N_PT;
  localparam int unsigned IMG_W     = AND_BITS + MASK_BITS;
  localparam int unsigned CNT_W     = $clog2(N_PT + 1);

  logic [IMG_W-1:0] shadow_q, shadow_d;
  logic [IMG_W-1:0] active_q, active_d;
  logic             err_q, err_d;
  logic [N_OUT-1:0] over;
  logic             shadow_en, active_en;

  // per-output selection count of the shadow image
  always_comb begin
    for (int o = 0; o < N_OUT; o++) begin
      logic [CNT_W-1:0] ones;
      ones = '0;
      for (int t = 0; t < N_PT; t++) begin
        ones = ones + {{(CNT_W-1){1'b0}}, shadow_q[AND_BITS + o*N_PT + t]};
      end
      over[o] = (ones > CNT_W'(TERM_LIMIT));
    end
  end

  // next state
  always_comb begin
    shadow_en = cfg_load;
    active_en = cfg_apply && !(|over);
    shadow_d  = {shadow_q[IMG_W-2:0], cfg_sin};
    active_d  = shadow_q;
    err_d     = err_q;
    if (cfg_apply) err_d = |over;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shadow_q <= '0;
      active_q <= '0;
      err_q    <= 1'b0;
    end else begin
      if (shadow_en) shadow_q <= shadow_d;
      if (active_en) active_q <= active_d;
      err_q <= err_d;
    end
  end

  assign cfg_sout = shadow_q[IMG_W-1];
  assign cfg_err  = err_q;
  assign and_cfg  = active_q[AND_BITS-1:0];
  assign mask_cfg = active_q[IMG_W-1:AND_BITS];

  AST_SHADOW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_load |=> $stable(shadow_q)); // R6
  AST_ACTIVE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_apply |=> $stable(active_q)); // R8
  AST_REJECT_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_apply && (|over)) |=> ($stable(active_q) && err_q)); // R9
  AST_ACCEPT_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_apply && !(|over)) |=> ((active_q == $past(shadow_q)) && !err_q)); // R9

  for (genvar o = 0; o < N_OUT; o++) begin : g_lim
    AST_ACTIVE_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(active_q[AND_BITS + o*N_PT +: N_PT]) <= TERM_LIMIT); // R9
  end
endmodule

// File: rtl/sop_and_plane.sv
module sop_and_plane
  import sop_pkg::*;
#(
  parameter int unsigned N_IN = 36,
  parameter int unsigned N_PT = 86
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic [N_IN-1:0]                 in_sig,
  input  logic [N_PT*(2*N_IN+1)-1:0]      and_cfg,
  output logic [N_PT-1:0]                 pterm
);
  localparam int unsigned N_COL = 2 * N_IN;
  localparam int unsigned PT_W  = N_COL + 1;

  logic [N_COL-1:0] lit;

  for (genvar i = 0; i < N_IN; i++) begin : g_lit
    assign lit[col_true(i)] = in_sig[i];
    assign lit[col_comp(i)] = ~in_sig[i];
  end

  for (genvar t = 0; t < N_PT; t++) begin : g_term
    logic [N_COL-1:0] conn;
    logic             used;
    assign conn     = and_cfg[t*PT_W +: N_COL];
    assign used     = and_cfg[t*PT_W + N_COL];
    assign pterm[t] = used & (&(lit | ~conn));

    AST_OPEN_TERM_ONE: assert property (@(posedge clk) disable iff (!rst_n)
      (used && (conn == '0)) |-> pterm[t]); // R2
    AST_UNUSED_TERM_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      !used |-> !pterm[t]); // R3
  end
endmodule

// File: rtl/sop_or_steer.sv
module sop_or_steer #(
  parameter int unsigned N_PT  = 86,
  parameter int unsigned N_OUT = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [N_PT-1:0]         pterm,
  input  logic [N_OUT*N_PT-1:0]   mask_cfg,
  output logic [N_OUT-1:0]        sum_out
);
  for (genvar o = 0; o < N_OUT; o++) begin : g_sum
    logic [N_PT-1:0] sel;
    assign sel        = mask_cfg[o*N_PT +: N_PT];
    assign sum_out[o] = |(sel & pterm);

    AST_EMPTY_SUM_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (sel == '0) |-> !sum_out[o]); // R5
  end
endmodule

// File: rtl/sop_block.sv
module sop_block
  import sop_pkg::*;
#(
  parameter int unsigned N_IN       = SOP_INPUTS,
  parameter int unsigned N_PT       = SOP_TERMS,
  parameter int unsigned N_OUT      = SOP_SUMS,
  parameter int unsigned TERM_LIMIT = SOP_TERM_LIMIT
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_IN-1:0]  in_sig,
  input  logic             cfg_load,
  input  logic             cfg_sin,
  input  logic             cfg_apply,
  output logic             cfg_sout,
  output logic             cfg_err,
  output logic [N_OUT-1:0] sum_out
);
  localparam int unsigned AND_BITS  = N_PT * (2 * N_IN + 1);
  localparam int unsigned MASK_BITS = N_OUT * N_PT;

  logic                 rst_sync_n;
  logic [AND_BITS-1:0]  and_cfg;
  logic [MASK_BITS-1:0] mask_cfg;
  logic [N_PT-1:0]      pterm;

  sop_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  sop_cfg_store #(
    .N_PT       (N_PT),
    .N_OUT      (N_OUT),
    .TERM_LIMIT (TERM_LIMIT),
    .AND_BITS   (AND_BITS)
  ) u_cfg (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .cfg_load  (cfg_load),
    .cfg_sin   (cfg_sin),
    .cfg_apply (cfg_apply),
    .cfg_sout  (cfg_sout),
    .cfg_err   (cfg_err),
    .and_cfg   (and_cfg),
    .mask_cfg  (mask_cfg)
  );

  sop_and_plane #(
    .N_IN (N_IN),
    .N_PT (N_PT)
  ) u_and (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .in_sig  (in_sig),
    .and_cfg (and_cfg),
    .pterm   (pterm)
  );

  sop_or_steer #(
    .N_PT  (N_PT),
    .N_OUT (N_OUT)
  ) u_or (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .pterm    (pterm),
    .mask_cfg (mask_cfg),
    .sum_out  (sum_out)
  );

  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_sync_n |-> (!cfg_err && (sum_out == '0))); // R10
endmodule

// File: tb/sop_block_test.sv
module sop_block_test;
  localparam int N_IN  = 36;
  localparam int N_PT  = 86;
  localparam int N_OUT = 16;
  localparam int N_COL = 2 * N_IN;
  localparam int PT_W  = N_COL + 1;
  localparam int MB    = N_PT * PT_W;
  localparam int IMG_W = MB + N_OUT * N_PT;

  logic             clk = 1'b0;
  logic             rst_n;
  logic [N_IN-1:0]  in_sig;
  logic             cfg_load, cfg_sin, cfg_apply;
  logic             cfg_sout, cfg_err;
  logic [N_OUT-1:0] sum_out;

  int vectors = 0;
  int misses  = 0;
  bit done    = 0;

  logic [IMG_W-1:0] act_m;
  logic [IMG_W-1:0] shadow_m;
  logic [IMG_W-1:0] nimg;

  always #2 clk = ~clk;

  sop_block uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_sig    (in_sig),
    .cfg_load  (cfg_load),
    .cfg_sin   (cfg_sin),
    .cfg_apply (cfg_apply),
    .cfg_sout  (cfg_sout),
    .cfg_err   (cfg_err),
    .sum_out   (sum_out)
  );

  task automatic check(input logic [15:0] act, input logic [15:0] exp, input string tag);
    vectors++;
    if (act !== exp) begin
      misses++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [N_OUT-1:0] model(input logic [IMG_W-1:0] img, input logic [N_IN-1:0] x);
    logic [N_PT-1:0]  pt;
    logic [N_OUT-1:0] s;
    for (int t = 0; t < N_PT; t++) begin
      pt[t] = img[t*PT_W + N_COL];
      for (int c = 0; c < N_COL; c++) begin
        if (img[t*PT_W + c]) begin
          if (((c % 2) == 0) ? !x[c/2] : x[c/2]) pt[t] = 1'b0;
        end
      end
    end
    for (int o = 0; o < N_OUT; o++) begin
      s[o] = 1'b0;
      for (int t = 0; t < N_PT; t++)
        if (img[MB + o*N_PT + t] && pt[t]) s[o] = 1'b1;
    end
    return s;
  endfunction

  function automatic logic [N_IN-1:0] rnd_in();
    return {$urandom, $urandom};
  endfunction

  task automatic clear_term(input int t);
    for (int c = 0; c <= N_COL; c++) nimg[t*PT_W + c] = 1'b0;
  endtask

  task automatic clear_mask(input int o);
    for (int t = 0; t < N_PT; t++) nimg[MB + o*N_PT + t] = 1'b0;
  endtask

  task automatic random_image();
    nimg = '0;
    for (int t = 0; t < N_PT; t++) begin
      int nl;
      nimg[t*PT_W + N_COL] = (($urandom % 8) != 0);
      nl = $urandom_range(0, 4);
      for (int k = 0; k < nl; k++) nimg[t*PT_W + ($urandom % N_COL)] = 1'b1;
    end
    for (int o = 0; o < N_OUT; o++) begin
      int want, got;
      want = $urandom_range(0, 16);
      got  = 0;
      while (got < want) begin
        int t;
        t = $urandom % N_PT;
        if (!nimg[MB + o*N_PT + t]) begin
          nimg[MB + o*N_PT + t] = 1'b1;
          got++;
        end
      end
    end
  endtask

  // R6 R7 R8: shift image MSB first, read back old shadow, outputs on old image
  task automatic load_image(input logic [IMG_W-1:0] img);
    for (int j = IMG_W - 1; j >= 0; j--) begin
      int n;
      @(negedge clk);
      n = IMG_W - 1 - j;
      if (n < 16) check({15'b0, cfg_sout}, {15'b0, shadow_m[IMG_W-1-n]}, "R6 serial readback");
      if ((n % 1000) == 500) begin
        in_sig = rnd_in();
        #1;
        check(sum_out, model(act_m, in_sig), "R8 outputs hold old image during load");
      end
      cfg_load = 1'b1;
      cfg_sin  = img[j];
    end
    @(negedge clk);
    cfg_load = 1'b0;
    cfg_sin  = 1'b0;
    shadow_m = img;
  endtask

  task automatic apply(input logic exp_err);
    @(negedge clk);
    cfg_apply = 1'b1;
    @(negedge clk);
    cfg_apply = 1'b0;
    check({15'b0, cfg_err}, {15'b0, exp_err}, "R9 error flag after apply");
    if (!exp_err) act_m = shadow_m;
  endtask

  // R1 R4 R11: combinational response, no clock edge between drive and sample
  task automatic run_vecs(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      in_sig = rnd_in();
      #1;
      check(sum_out, model(act_m, in_sig), "R1 R4 R11 random vector");
      in_sig = ~in_sig;
      #0.5;
      check(sum_out, model(act_m, in_sig), "R11 change without clock");
    end
  endtask

  task automatic directed(input logic [N_IN-1:0] x);
    @(negedge clk);
    in_sig = x;
    #1;
    check({15'b0, sum_out[0]}, 16'd1, "R2 open used term");
    check({15'b0, sum_out[1]}, 16'd0, "R3 unused term forced low");
    check({15'b0, sum_out[2]}, 16'd0, "R5 empty output");
    check({15'b0, sum_out[3]}, {15'b0, x[0] | ~x[5]}, "R4 shared term sum");
    check({15'b0, sum_out[4]}, {15'b0, x[0]}, "R4 R1 shared true literal");
    check(sum_out, model(act_m, x), "R4 sixteen-term output");
  endtask

  initial begin
    void'($urandom(32'd2024));
    rst_n = 1'b0; in_sig = '0; cfg_load = 1'b0; cfg_sin = 1'b0; cfg_apply = 1'b0;
    act_m = '0; shadow_m = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    in_sig = rnd_in();
    #1;
    check(sum_out, 16'd0, "R10 reset sums");
    check({15'b0, cfg_err}, 16'd0, "R10 reset error flag");
    check({15'b0, cfg_sout}, 16'd0, "R10 reset serial out");
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // random image, accepted
    random_image();
    load_image(nimg);
    apply(1'b0);
    run_vecs(200);

    // directed image
    random_image();
    for (int t = 0; t < 4; t++) clear_term(t);
    nimg[0*PT_W + N_COL] = 1'b1;
    nimg[1*PT_W + N_COL] = 1'b0;
    nimg[2*PT_W + N_COL] = 1'b1; nimg[2*PT_W + 0]  = 1'b1;
    nimg[3*PT_W + N_COL] = 1'b1; nimg[3*PT_W + 11] = 1'b1;
    for (int o = 0; o < 5; o++) clear_mask(o);
    clear_mask(15);
    nimg[MB + 0*N_PT + 0] = 1'b1;
    nimg[MB + 1*N_PT + 1] = 1'b1;
    nimg[MB + 3*N_PT + 2] = 1'b1; nimg[MB + 3*N_PT + 3] = 1'b1;
    nimg[MB + 4*N_PT + 2] = 1'b1;
    for (int t = 70; t < 86; t++) nimg[MB + 15*N_PT + t] = 1'b1;
    load_image(nimg);
    apply(1'b0);
    directed('0);
    directed(36'h21);
    directed(36'h20);
    directed(36'h1);
    run_vecs(150);

    // over-limit image, refused
    nimg = act_m;
    clear_mask(7);
    for (int t = 0; t < 17; t++) nimg[MB + 7*N_PT + t] = 1'b1;
    load_image(nimg);
    apply(1'b1);
    directed(36'h21);
    run_vecs(100);

    // fresh accepted image clears the flag
    random_image();
    load_image(nimg);
    apply(1'b0);
    run_vecs(150);

    // idle cycles with load low: next load must read back unchanged shadow
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      cfg_sin = $urandom;
    end
    cfg_sin = 1'b0;
    random_image();
    load_image(nimg);
    apply(1'b0);
    run_vecs(50);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      vectors++;
      misses++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end
endmodule